// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock line waveform for an I2C master from the functional clock. A programmable prescaler turns the functional clock into a slower count tick. Two phase counters then time how long the clock line is pulled low and how long it is left released. The bit engine beside it uses two single-cycle strobes to place its data changes and samples. START, STOP, data shifting and arbitration belong to that bit engine, not to this block.

Configuration is loaded through a one-cycle write port. A write carries a mode, a prescaler value and two packed count words. In standard and fast mode only the lower byte of each count word is used. Software chooses a symmetric split for standard mode and roughly a 2/3 low, 1/3 high split for fast mode. High-speed mode keeps two byte fields in each count word: the lower byte times the arbitration phase and the upper byte times the high-speed phase, selected by `hs_sel_i`. A write is taken only while the block is disabled. A write with a zero prescaler, a zero count field in use, or the reserved mode code is rejected: it sets the error flag and leaves the stored configuration as it was.

After the low count has run out, the line is released. The high count starts only once the sampled line reads high, so a slave that stretches the clock lengthens the released time.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset the line is released, both strobes and the error flag are low, and the stored configuration is standard mode (code 0), prescaler 1, low byte 3, high byte 3.
- R2: Every prescaled tick lasts prescaler + 1 functional clock cycles, and the prescaler count is held at zero outside the counted phases.
- R3: Each low phase drives the line low for (low field + LOW_TRIM) × (prescaler + 1) cycles.
- R4: After the line is released, the block waits in a non-counting state until `scl_i` is sampled high. Each cycle of stretching adds one cycle to the released time, and no rise strobe is given while the line is held low.
- R5: Once `scl_i` is seen high, the high phase lasts (high field + HIGH_TRIM) × (prescaler + 1) cycles before the line is driven low again. With an unstretched line, the released time is one cycle longer than that.
- R6: In standard mode (code 0) and fast mode (code 1) the low and high fields are bits [7:0] of the count words, and bits [15:8] have no effect on timing or on validation.
- R7: In high-speed mode (code 2) bits [7:0] are used when `hs_sel_i` is 0 and bits [15:8] when it is 1.
- R8: A disabled write with prescaler 0, mode code 3, a zero lower byte, or in high-speed mode a zero upper byte sets `cfg_err_o` and leaves the timing unchanged. An accepted write clears `cfg_err_o`.
- R9: A write while `en_i` is high changes neither the stored configuration nor `cfg_err_o`.
- R10: Dropping `en_i` releases the line from the next cycle and keeps it released with no strobes. Raising `en_i` starts with a low phase.
- R11: `fall_stb_o` is high in the first cycle of every low phase, and `rise_stb_o` is high in the first cycle of every counted high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low holds the generator idle with the line released |
| cfg_we_i | input | 1 | One-cycle configuration write |
| cfg_mode_i | input | 2 | Mode code: 0 standard, 1 fast, 2 high-speed, 3 reserved |
| cfg_psc_i | input | PSC_W | Prescaler value (tick = value + 1 cycles) |
| cfg_low_i | input | 2*FIELD_W | Packed low counts, upper field for high-speed phase |
| cfg_high_i | input | 2*FIELD_W | Packed high counts, upper field for high-speed phase |
| hs_sel_i | input | 1 | Selects the high-speed phase fields in high-speed mode |
| scl_i | input | 1 | Sampled (already synchronized) clock line level |
| scl_drive_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| fall_stb_o | output | 1 | Pulse in the first cycle of a low phase |
| rise_stb_o | output | 1 | Pulse in the first cycle of a counted high phase |
| cfg_err_o | output | 1 | Last disabled write was rejected |

## Verification
The hardest case to reach from the ports is clock stretching. It needs the line held low from outside while the block has already released it, and released again at a known cycle. The bench models the open-drain line as the AND of the block's release and a bench-held stretch flag. The flag is raised before enabling and dropped a counted number of cycles into the released time. The bench then checks that the released time grows by exactly that count and that no rise strobe comes out while the line is held. Rejected writes are followed by a full timed period, to show at the line that the stored timing survived.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_HS   = 2'd2,
    MODE_RSVD = 2'd3
  } scl_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/i2c_scl_cfg.sv
module i2c_scl_cfg
  import i2c_scl_pkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int FIELD_W  = 8,
  parameter int DEF_PSC  = 1,
  parameter int DEF_LOW  = 3,
  parameter int DEF_HIGH = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic [1:0]           mode_i,
  input  logic [PSC_W-1:0]     psc_i,
  input  logic [2*FIELD_W-1:0] low_i,
  input  logic [2*FIELD_W-1:0] high_i,
  input  logic                 hs_sel_i,
  output logic [PSC_W-1:0]     psc_o,
  output logic [FIELD_W-1:0]   low_o,
  output logic [FIELD_W-1:0]   high_o,
  output logic                 err_o
);
  localparam int WORD_W = 2 * FIELD_W;

  scl_mode_e          mode_q;
  logic [PSC_W-1:0]   psc_q;
  logic [WORD_W-1:0]  low_q, high_q;
  logic [1:0]         low_nz, high_nz;
  logic               is_hs, valid, take, reject, use_hi;

  for (genvar g = 0; g < 2; g++) begin : g_field
    assign low_nz[g]  = |low_i[g*FIELD_W +: FIELD_W];
    assign high_nz[g] = |high_i[g*FIELD_W +: FIELD_W];
  end

  assign is_hs  = (mode_i == MODE_HS);
  assign valid  = (|psc_i) && (mode_i != MODE_RSVD) && low_nz[0] && high_nz[0]
                  && (!is_hs || (low_nz[1] && high_nz[1]));
  assign take   = we_i && !en_i && valid;
  assign reject = we_i && !en_i && !valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STD;
      psc_q  <= PSC_W'(DEF_PSC);
      low_q  <= WORD_W'(DEF_LOW);
      high_q <= WORD_W'(DEF_HIGH);
      err_o  <= 1'b0;
    end else if (take) begin
      mode_q <= scl_mode_e'(mode_i);
      psc_q  <= psc_i;
      low_q  <= low_i;
      high_q <= high_i;
      err_o  <= 1'b0;
    end else if (reject) begin
      err_o  <= 1'b1;
    end
  end

  assign use_hi = (mode_q == MODE_HS) && hs_sel_i;
  assign psc_o  = psc_q;
  assign low_o  = use_hi ? low_q[WORD_W-1:FIELD_W]  : low_q[FIELD_W-1:0];
  assign high_o = use_hi ? high_q[WORD_W-1:FIELD_W] : high_q[FIELD_W-1:0];

  assert_locked_when_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q)
                        && $stable(mode_q) && $stable(err_o)));

  assert_zero_psc_rejected_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !en_i && psc_i == '0) |=> (err_o && $stable(psc_q)));

  assert_stored_psc_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_q != '0);

endmodule

// File: rtl/i2c_scl_presc.sv
module i2c_scl_presc #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_presc_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= psc_i));

  assert_presc_parked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase
  import i2c_scl_pkg::*;
#(
  parameter int FIELD_W   = 8,
  parameter int LOW_TRIM  = 2,
  parameter int HIGH_TRIM = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               scl_i,
  input  logic [FIELD_W-1:0] low_i,
  input  logic [FIELD_W-1:0] high_i,
  output logic               run_o,
  output logic               drive_low_o,
  output logic               fall_stb_o,
  output logic               rise_stb_o
);
  localparam int CNT_W = FIELD_W + 2;

  scl_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, low_tgt, high_tgt, tgt;
  logic             last, fall_d, rise_d;

  assign low_tgt  = CNT_W'(low_i) + CNT_W'(LOW_TRIM);
  assign high_tgt = CNT_W'(high_i) + CNT_W'(HIGH_TRIM);
  assign tgt      = (ph_q == PH_HIGH) ? high_tgt : low_tgt;
  assign last     = tick_i && (cnt_q == tgt - 1'b1);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    fall_d = 1'b0;
    rise_d = 1'b0;
    if (!en_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_LOW;
          cnt_d  = '0;
          fall_d = 1'b1;
        end
        PH_LOW: begin
          if (last) begin
            ph_d  = PH_WAIT;
            cnt_d = '0;
          end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_WAIT: begin
          if (scl_i) begin
            ph_d   = PH_HIGH;
            rise_d = 1'b1;
          end
        end
        PH_HIGH: begin
          if (last) begin
            ph_d   = PH_LOW;
            cnt_d  = '0;
            fall_d = 1'b1;
          end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      fall_stb_o <= 1'b0;
      rise_stb_o <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      cnt_q      <= cnt_d;
      fall_stb_o <= fall_d;
      rise_stb_o <= rise_d;
    end
  end

  assign drive_low_o = (ph_q == PH_LOW);
  assign run_o       = en_i && ((ph_q == PH_LOW) || (ph_q == PH_HIGH));

  assert_release_on_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drive_low_o);

  assert_rise_after_line_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |-> $past(scl_i));

  assert_fall_marks_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |-> drive_low_o);

  assert_count_below_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_LOW) || (ph_q == PH_HIGH)) |-> (cnt_q < tgt));

  assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_stb_o, rise_stb_o}));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int PSC_W     = 8,
  parameter int FIELD_W   = 8,
  parameter int LOW_TRIM  = 2,
  parameter int HIGH_TRIM = 1,
  parameter int DEF_PSC   = 1,
  parameter int DEF_LOW   = 3,
  parameter int DEF_HIGH  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic [PSC_W-1:0]     cfg_psc_i,
  input  logic [2*FIELD_W-1:0] cfg_low_i,
  input  logic [2*FIELD_W-1:0] cfg_high_i,
  input  logic                 hs_sel_i,
  input  logic                 scl_i,
  output logic                 scl_drive_low_o,
  output logic                 fall_stb_o,
  output logic                 rise_stb_o,
  output logic                 cfg_err_o
);
  logic [PSC_W-1:0]   psc;
  logic [FIELD_W-1:0] low_f, high_f;
  logic               run, tick;

  i2c_scl_cfg #(
    .PSC_W(PSC_W), .FIELD_W(FIELD_W),
    .DEF_PSC(DEF_PSC), .DEF_LOW(DEF_LOW), .DEF_HIGH(DEF_HIGH)
  ) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(cfg_we_i),
    .mode_i(cfg_mode_i), .psc_i(cfg_psc_i), .low_i(cfg_low_i), .high_i(cfg_high_i),
    .hs_sel_i(hs_sel_i), .psc_o(psc), .low_o(low_f), .high_o(high_f), .err_o(cfg_err_o)
  );

  i2c_scl_presc #(.PSC_W(PSC_W)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .psc_i(psc), .tick_o(tick)
  );

  i2c_scl_phase #(
    .FIELD_W(FIELD_W), .LOW_TRIM(LOW_TRIM), .HIGH_TRIM(HIGH_TRIM)
  ) phase_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .scl_i(scl_i),
    .low_i(low_f), .high_i(high_f), .run_o(run), .drive_low_o(scl_drive_low_o),
    .fall_stb_o(fall_stb_o), .rise_stb_o(rise_stb_o)
  );

endmodule

// File: tb/i2c_scl_gen_tb_top.sv
module i2c_scl_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_mode_i = '0;
  logic [7:0]  cfg_psc_i = '0;
  logic [15:0] cfg_low_i = '0;
  logic [15:0] cfg_high_i = '0;
  logic        hs_sel_i = 1'b0;
  logic        hold = 1'b0;
  logic        scl_i;
  logic        drv, fall_stb, rise_stb, err;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;
  assign scl_i = !drv && !hold;

  i2c_scl_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cfg_we_i(cfg_we_i),
    .cfg_mode_i(cfg_mode_i), .cfg_psc_i(cfg_psc_i), .cfg_low_i(cfg_low_i),
    .cfg_high_i(cfg_high_i), .hs_sel_i(hs_sel_i), .scl_i(scl_i),
    .scl_drive_low_o(drv), .fall_stb_o(fall_stb), .rise_stb_o(rise_stb), .cfg_err_o(err)
  );

  // trims: low 2, high 1; low = (f+2)*(p+1), released = 1 + (h+1)*(p+1)
  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  psc;
    logic [15:0] lo;
    logic [15:0] hi;
    logic        sel;
    logic [15:0] exp_lo;
    logic [15:0] exp_rel;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd1, 16'h0003, 16'h0003, 1'b0, 16'd10, 16'd9},
    '{2'd1, 8'd2, 16'h0004, 16'h0001, 1'b0, 16'd18, 16'd7},
    '{2'd2, 8'd1, 16'h0203, 16'h0105, 1'b0, 16'd10, 16'd13},
    '{2'd2, 8'd1, 16'h0203, 16'h0105, 1'b1, 16'd8,  16'd5},
    '{2'd0, 8'd3, 16'h0001, 16'h0002, 1'b0, 16'd12, 16'd13},
    '{2'd1, 8'd1, 16'hFF01, 16'hAA02, 1'b0, 16'd6,  16'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic [7:0] p,
                           input logic [15:0] lo, input logic [15:0] hi);
    cfg_mode_i = m; cfg_psc_i = p; cfg_low_i = lo; cfg_high_i = hi; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // en_i rises, time one low phase and the following released time
  task automatic run_period(output int lo_n, output int rel_n, output int fall_ok,
                            output int rise_n);
    lo_n = 0; rel_n = 0; fall_ok = 0; rise_n = 0;
    en_i = 1'b1;
    @(negedge clk_i);
    while (!drv) @(negedge clk_i);
    fall_ok = int'(fall_stb);
    while (drv) begin lo_n++; @(negedge clk_i); end
    while (!drv) begin rel_n++; rise_n += int'(rise_stb); @(negedge clk_i); end
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lo_n, rel_n, f_ok, r_n;
    repeat (3) @(negedge clk_i);
    chk("R1 drive in reset", int'(drv), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 drive", int'(drv), 0);
    chk("R1 fall strobe", int'(fall_stb), 0);
    chk("R1 rise strobe", int'(rise_stb), 0);
    chk("R1 err", int'(err), 0);
    repeat (3) @(negedge clk_i);
    chk("R10 idle stays released", int'(drv), 0);
    run_period(lo_n, rel_n, f_ok, r_n);
    chk("R1 default low", lo_n, 10);
    chk("R1 default released", rel_n, 9);

    // R2 R3 R5 R6 R7 R11: table walk
    for (int i = 0; i < 6; i++) begin
      hs_sel_i = VECS[i].sel;
      write_cfg(VECS[i].mode, VECS[i].psc, VECS[i].lo, VECS[i].hi);
      chk("R8 accepted write err", int'(err), 0);
      run_period(lo_n, rel_n, f_ok, r_n);
      chk((VECS[i].mode == 2) ? "R7 low phase" : "R3 R6 low phase", lo_n, int'(VECS[i].exp_lo));
      chk((VECS[i].mode == 2) ? "R7 released" : "R5 R2 released", rel_n, int'(VECS[i].exp_rel));
      chk("R11 fall strobe", f_ok, 1);
      chk("R11 rise strobe count", r_n, 1);
    end
    hs_sel_i = 1'b0;

    // R8: rejected writes keep timing
    write_cfg(2'd0, 8'd1, 16'h0003, 16'h0003);
    write_cfg(2'd0, 8'd0, 16'h0005, 16'h0005);
    chk("R8 zero psc err", int'(err), 1);
    write_cfg(2'd3, 8'd2, 16'h0005, 16'h0005);
    chk("R8 reserved mode err", int'(err), 1);
    write_cfg(2'd1, 8'd2, 16'h0500, 16'h0005);
    chk("R8 zero low byte err", int'(err), 1);
    write_cfg(2'd2, 8'd2, 16'h0505, 16'h0005);
    chk("R8 hs zero upper err", int'(err), 1);
    run_period(lo_n, rel_n, f_ok, r_n);
    chk("R8 low kept", lo_n, 10);
    chk("R8 released kept", rel_n, 9);
    write_cfg(2'd0, 8'd1, 16'h0003, 16'h0003);
    chk("R8 err cleared", int'(err), 0);

    // R9: write while enabled ignored
    write_cfg(2'd0, 8'd0, 16'h0000, 16'h0000);
    chk("R9 setup err", int'(err), 1);
    en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    write_cfg(2'd1, 8'd3, 16'h0001, 16'h0002);
    chk("R9 err unchanged", int'(err), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    run_period(lo_n, rel_n, f_ok, r_n);
    chk("R9 low unchanged", lo_n, 10);
    chk("R9 released unchanged", rel_n, 9);

    // R10: disable mid low phase
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10 low after enable", int'(drv), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R10 released next cycle", int'(drv), 0);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        seen += int'(drv) + int'(fall_stb) + int'(rise_stb);
        @(negedge clk_i);
      end
      chk("R10 quiet while disabled", seen, 0);
    end

    // R4: stretch 6 cycles; released = 6 + (3+1)*(1+1)
    hold = 1'b1;
    en_i = 1'b1;
    @(negedge clk_i);
    while (!drv) @(negedge clk_i);
    lo_n = 0;
    while (drv) begin lo_n++; @(negedge clk_i); end
    chk("R3 low before stretch", lo_n, 10);
    rel_n = 0; r_n = 0;
    for (int k = 0; k < 6; k++) begin
      rel_n++; r_n += int'(rise_stb) + int'(drv);
      if (k == 5) hold = 1'b0;
      @(negedge clk_i);
    end
    chk("R4 no rise while held", r_n, 0);
    chk("R11 rise at first high cycle", int'(rise_stb), 1);
    while (!drv) begin rel_n++; @(negedge clk_i); end
    chk("R4 stretched released", rel_n, 14);
    en_i = 1'b0;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule